// File: doc/BRIEF.md
# Self-Calibrating Serial Debug Port

This block is the serial front end of a debug link. It needs no programmed divisor. After reset it holds its output high and treats the input line only as a timing source. It waits for the host's calibration character, 80h, whose start bit and seven zero data bits make a single low span of eight bit-times. The block counts that span in system clocks and divides it by eight to get the bit period. From then on it receives and sends characters at that rate. The transmitter ends each character with one and a half stop bits.

While calibrated, the port watches for a break, which is a low level that lasts well past the length of any character. A break drops the port back to the uncalibrated state, and the host must send 80h again, possibly at a new rate. The serial input passes through a short synchronizer before any logic uses it. All timings below count clocks at the synchronized line.

Top module: `sdp_autobaud_port`

## Requirements
- R1: A transmitted character is a low start bit, then eight data bits with the least significant bit first, then a high stop level. The start and data bits each last one bit period P. The stop level lasts P + (P >> 1) clocks. The output is high whenever the transmitter is idle.
- R2: Out of reset the port is uncalibrated. In this state tx_ready is 0, ser_out stays 1, tx_start has no effect and rx_valid never pulses.
- R3: When uncalibrated with the line high, a low span of L clocks followed by a return to high sets P = L >> 3 and calibrates the port. The calibration character itself is not delivered on rx_byte.
- R4: A measurement with L >> 3 below MIN_PER (default 4) is discarded and the port stays uncalibrated. A low span that saturates the CNT_W-bit counter is also discarded, and the port then waits for the line to go high before it measures again.
- R5: When calibrated, a falling edge starts reception. The start bit is re-checked P >> 1 clocks after the edge, and each data bit is sampled one P later than the previous sample, least significant bit first. A high stop sample gives a one-cycle rx_valid pulse with the byte on rx_byte.
- R6: A low stop sample gives a one-cycle rx_frame_err pulse and no rx_valid. The receiver then waits for the line to go high.
- R7: When calibrated, a low level that lasts 9·P + (P >> 1) clocks is a break and returns the port to the uncalibrated state. A 00h character with a correct stop bit is not a break.
- R8: tx_start is taken only on a cycle where tx_ready is 1. After the start is taken, tx_ready stays 0 for exactly 10·P + (P >> 1) cycles.
- R9: After a break, a new calibration at a different rate gives correct reception and transmission at the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial line from the host, high when idle |
| ser_out | output | 1 | Serial line to the host, high when idle |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is new |
| rx_frame_err | output | 1 | One-cycle pulse on a low stop sample |
| tx_byte | input | 8 | Byte to send |
| tx_start | input | 1 | Send request, taken when tx_ready is high |
| tx_ready | output | 1 | Calibrated and transmitter idle |

## Verification
The assertions check on every cycle that the port stays silent while uncalibrated. They also check that the learned period never falls below the minimum, that a break or a counter overflow leaves the port uncalibrated, that valid and framing-error pulses never coincide, and that the transmitter drives its start and stop levels correctly. Only the bench scenarios can show that the learned period matches the calibration timing. The same goes for exact bit positions and stop length on the wire, byte values across a full sweep of codes, rejection of short and overlong spans, and recalibration after a break at new rates up to the slowest one.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [1:0] {DET_WAIT_HI, DET_IDLE, DET_MEAS, DET_LOCK} sdp_det_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} sdp_rx_t;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} sdp_tx_t;

  // bit period from an eight-bit-time low span
  function automatic int unsigned sdp_bit_period(input int unsigned span);
    return span >> 3;
  endfunction

  // offset from a start edge to the middle of the start bit
  function automatic int unsigned sdp_half(input int unsigned per);
    return per >> 1;
  endfunction

  // transmitted stop length: one and a half bit periods
  function automatic int unsigned sdp_stop_len(input int unsigned per);
    return per + (per >> 1);
  endfunction

  // low length that counts as a break
  function automatic int unsigned sdp_brk_lim(input int unsigned per);
    return 9 * per + (per >> 1);
  endfunction

  // full transmit occupancy in clocks
  function automatic int unsigned sdp_tx_len(input int unsigned per);
    return 9 * per + sdp_stop_len(per);
  endfunction

endpackage

// File: rtl/sdp_rate_learn.sv
module sdp_rate_learn
  import sdp_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int PER_W   = CNT_W - 3,
  parameter int MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic             locked,
  output logic [PER_W-1:0] per,
  output logic             brk_evt,
  output logic             ovf_evt
);

  sdp_det_t         st;
  logic [CNT_W-1:0] span;
  logic [CNT_W:0]   run;

  int unsigned      cand_i;
  int unsigned      lim_i;
  logic [PER_W-1:0] cand;
  logic             meas_end;
  logic             meas_ok;

  always_comb begin
    cand_i   = sdp_bit_period(32'(span));
    lim_i    = sdp_brk_lim(32'(per));
    cand     = cand_i[PER_W-1:0];
    meas_end = (st == DET_MEAS) && line;
    meas_ok  = meas_end && (cand_i >= 32'(MIN_PER));
    ovf_evt  = (st == DET_MEAS) && !line && (span == '1);
    brk_evt  = (st == DET_LOCK) && !line && ((32'(run) + 32'd1) == lim_i);
  end

  assign locked = (st == DET_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= DET_WAIT_HI;
      span <= '0;
      run  <= '0;
      per  <= '0;
    end else begin
      unique case (st)
        DET_WAIT_HI: if (line) st <= DET_IDLE;
        DET_IDLE: begin
          if (!line) begin
            st   <= DET_MEAS;
            span <= CNT_W'(1);
          end
        end
        DET_MEAS: begin
          if (line) begin
            if (meas_ok) begin
              st  <= DET_LOCK;
              per <= cand;
              run <= '0;
            end else begin
              st <= DET_IDLE;
            end
          end else if (ovf_evt) begin
            st <= DET_WAIT_HI;
          end else begin
            span <= span + CNT_W'(1);
          end
        end
        DET_LOCK: begin
          if (brk_evt) begin
            st  <= DET_WAIT_HI;
            run <= '0;
          end else if (line) begin
            run <= '0;
          end else begin
            run <= run + (CNT_W+1)'(1);
          end
        end
        default: st <= DET_WAIT_HI;
      endcase
    end
  end

  // R4: a calibrated port never holds a period below the minimum
  p_min_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (32'(per) >= 32'(MIN_PER)));

  // R4: overflow leaves the port uncalibrated and waiting for a high line
  p_ovf_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (st == DET_WAIT_HI));

  // R7: a break always drops calibration
  p_break_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !locked);

  // R3: calibration happens only at the end of a measured span
  p_lock_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_ok));

endmodule

// File: rtl/sdp_rx.sv
module sdp_rx
  import sdp_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             line,
  input  logic [PER_W-1:0] per,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             rx_ferr
);

  sdp_rx_t          st;
  logic [PER_W-1:0] tmr;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  int unsigned      half_i;
  logic [PER_W-1:0] half;
  logic             tick;

  always_comb begin
    half_i = sdp_half(32'(per));
    half   = half_i[PER_W-1:0];
    tick   = (tmr == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      sh       <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        unique case (st)
          RX_IDLE: begin
            if (!line) begin
              st  <= RX_START;
              tmr <= half - PER_W'(1);
            end
          end
          RX_START: begin
            if (tick) begin
              if (line) begin
                st <= RX_IDLE;
              end else begin
                st   <= RX_DATA;
                tmr  <= per - PER_W'(1);
                bitn <= '0;
              end
            end else begin
              tmr <= tmr - PER_W'(1);
            end
          end
          RX_DATA: begin
            if (tick) begin
              sh   <= {line, sh[7:1]};
              bitn <= bitn + 3'd1;
              tmr  <= per - PER_W'(1);
              if (bitn == 3'd7) st <= RX_STOP;
            end else begin
              tmr <= tmr - PER_W'(1);
            end
          end
          RX_STOP: begin
            if (tick) begin
              if (line) begin
                rx_valid <= 1'b1;
                rx_byte  <= sh;
                st       <= RX_IDLE;
              end else begin
                rx_ferr <= 1'b1;
                st      <= RX_HOLD;
              end
            end else begin
              tmr <= tmr - PER_W'(1);
            end
          end
          RX_HOLD: if (line) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R6: a stop sample yields either a byte or a framing error, never both
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ferr));

  // R5: valid is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: after a framing error the receiver cannot start before the line is high
  p_ferr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ferr && en && !line) |-> (st == RX_HOLD));

endmodule

// File: rtl/sdp_tx.sv
module sdp_tx
  import sdp_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] per,
  input  logic [7:0]       tx_byte,
  input  logic             tx_start,
  output logic             tx_ready,
  output logic             ser_out
);

  localparam int TW = PER_W + 1;

  sdp_tx_t     st;
  logic [TW-1:0] tmr;
  logic [2:0]  bitn;
  logic [7:0]  sh;

  int unsigned   stop_i;
  logic [TW-1:0] stop_len;
  logic [TW-1:0] per_w;
  logic          tick;
  logic          accept;

  always_comb begin
    stop_i   = sdp_stop_len(32'(per));
    stop_len = stop_i[TW-1:0];
    per_w    = {1'b0, per};
    tick     = (tmr == '0);
  end

  assign tx_ready = en && (st == TX_IDLE);
  assign accept   = tx_start && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      tmr     <= '0;
      bitn    <= '0;
      sh      <= '0;
      ser_out <= 1'b1;
    end else if (!en) begin
      st      <= TX_IDLE;
      ser_out <= 1'b1;
    end else begin
      unique case (st)
        TX_IDLE: begin
          ser_out <= 1'b1;
          if (accept) begin
            sh      <= tx_byte;
            ser_out <= 1'b0;
            tmr     <= per_w - TW'(1);
            st      <= TX_START;
          end
        end
        TX_START: begin
          if (tick) begin
            ser_out <= sh[0];
            sh      <= {1'b0, sh[7:1]};
            bitn    <= '0;
            tmr     <= per_w - TW'(1);
            st      <= TX_DATA;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        TX_DATA: begin
          if (tick) begin
            if (bitn == 3'd7) begin
              ser_out <= 1'b1;
              tmr     <= stop_len - TW'(1);
              st      <= TX_STOP;
            end else begin
              ser_out <= sh[0];
              sh      <= {1'b0, sh[7:1]};
              bitn    <= bitn + 3'd1;
              tmr     <= per_w - TW'(1);
            end
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        TX_STOP: begin
          if (tick) st <= TX_IDLE;
          else      tmr <= tmr - TW'(1);
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R8: a taken request puts the start level on the line next cycle
  p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ser_out);

  // R1: the line is high whenever a new byte could be taken
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ser_out);

  // R1: the stop level is high throughout
  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_STOP) |-> ser_out);

endmodule

// File: rtl/sdp_autobaud_port.sv
module sdp_autobaud_port
  import sdp_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int MIN_PER     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  output logic       ser_out,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_frame_err,
  input  logic [7:0] tx_byte,
  input  logic       tx_start,
  output logic       tx_ready
);

  localparam int PER_W = CNT_W - 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   locked;
  logic [PER_W-1:0]       per;
  logic                   brk_evt;
  logic                   ovf_evt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= ser_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ser_in};
      end
    end
  endgenerate

  assign line = sync_q[SYNC_STAGES-1];

  sdp_rate_learn #(
    .CNT_W   (CNT_W),
    .PER_W   (PER_W),
    .MIN_PER (MIN_PER)
  ) u_learn (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (line),
    .locked  (locked),
    .per     (per),
    .brk_evt (brk_evt),
    .ovf_evt (ovf_evt)
  );

  sdp_rx #(.PER_W(PER_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (locked),
    .line     (line),
    .per      (per),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_frame_err)
  );

  sdp_tx #(.PER_W(PER_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (locked),
    .per      (per),
    .tx_byte  (tx_byte),
    .tx_start (tx_start),
    .tx_ready (tx_ready),
    .ser_out  (ser_out)
  );

  // R2: an uncalibrated port offers no handshake and delivers no byte
  p_quiet_uncal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!tx_ready && !rx_valid));

  // R2: out of reset the port is uncalibrated
  p_reset_uncal_r2: assert property (@(posedge clk)
    !rst_n |=> !locked);

endmodule

// File: tb/sdp_autobaud_port_test.sv
module sdp_autobaud_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b1;
  logic       tx_start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       ser_out;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_frame_err;
  logic       tx_ready;

  int n_run = 0;
  int n_fail = 0;
  int n_valid = 0;
  int n_ferr = 0;
  logic [7:0] last_rx = 8'h00;

  always #2 clk = ~clk;

  sdp_autobaud_port uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_in       (ser_in),
    .ser_out      (ser_out),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .tx_byte      (tx_byte),
    .tx_start     (tx_start),
    .tx_ready     (tx_ready)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      n_valid++;
      last_rx = rx_byte;
    end
    if (rx_frame_err) n_ferr++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_level(input bit v, input int n);
    ser_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input int p, input bit stop_low);
    put_level(1'b0, p);
    for (int i = 0; i < 8; i++) put_level(b[i], p);
    if (stop_low) put_level(1'b0, p);
    put_level(1'b1, 3 * p);
  endtask

  task automatic calibrate(input int p);
    int v0;
    v0 = n_valid;
    send_char(8'h80, p, 1'b0);
    chk(tx_ready == 1'b1, "R3 calibrated", int'(tx_ready), 1);
    chk(n_valid == v0, "R3 calibration char not delivered", n_valid - v0, 0);
  endtask

  task automatic rx_check(input logic [7:0] b, input int p, input string tag);
    int v0, f0;
    v0 = n_valid;
    f0 = n_ferr;
    send_char(b, p, 1'b0);
    chk(n_valid == v0 + 1 && last_rx == b && n_ferr == f0, tag, int'(last_rx), int'(b));
  endtask

  task automatic brk(input int p);
    put_level(1'b0, 10 * p + 8);
    chk(tx_ready == 1'b0, "R7 break drops calibration", int'(tx_ready), 0);
    put_level(1'b1, 10);
  endtask

  task automatic tx_check(input logic [7:0] b, input int p);
    int total, errs_o, errs_r, idx;
    bit exp_o, exp_r;
    total  = 10 * p + p / 2;
    errs_o = 0;
    errs_r = 0;
    chk(tx_ready == 1'b1, "R8 ready before send", int'(tx_ready), 1);
    tx_byte  = b;
    tx_start = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= total + 3; n++) begin
      @(negedge clk);
      if (n == 1) tx_start = 1'b0;
      idx   = (n - 1) / p;
      exp_o = (idx == 0) ? 1'b0 : (idx <= 8) ? b[idx-1] : 1'b1;
      exp_r = ((n - 1) >= total);
      if (ser_out !== exp_o) errs_o++;
      if (tx_ready !== exp_r) errs_r++;
    end
    chk(errs_o == 0, "R1 transmit waveform", errs_o, 0);
    chk(errs_r == 0, "R8 ready gap length", errs_r, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: reset state and ignored tx_start
    chk(tx_ready == 1'b0, "R2 reset tx_ready", int'(tx_ready), 0);
    chk(ser_out == 1'b1, "R2 reset ser_out", int'(ser_out), 1);
    tx_byte  = 8'h00;
    tx_start = 1'b1;
    lows = 0;
    repeat (30) begin
      @(negedge clk);
      if (ser_out !== 1'b1) lows++;
    end
    tx_start = 1'b0;
    chk(lows == 0, "R2 tx_start ignored while uncalibrated", lows, 0);
    chk(n_valid == 0, "R2 no rx_valid while uncalibrated", n_valid, 0);

    // R4: span too short (8 clocks -> period 1)
    send_char(8'h55, 8, 1'b0);
    chk(tx_ready == 1'b0, "R4 short span rejected", int'(tx_ready), 0);
    chk(n_valid == 0, "R4 no byte from rejected span", n_valid, 0);

    // R4: counter overflow
    put_level(1'b0, 8300);
    put_level(1'b1, 20);
    chk(tx_ready == 1'b0, "R4 overflow rejected", int'(tx_ready), 0);

    // P = 4: full byte sweep
    calibrate(4);
    for (int v = 0; v < 256; v++) rx_check(8'(v), 4, "R5 rx sweep P=4");
    tx_check(8'h00, 4);
    tx_check(8'hFF, 4);
    tx_check(8'hA5, 4);
    tx_check(8'h01, 4);
    tx_check(8'h80, 4);

    // R9: recalibration at P = 5
    brk(4);
    calibrate(5);
    for (int v = 0; v < 256; v += 37) rx_check(8'(v), 5, "R9 rx after recalibration P=5");
    tx_check(8'h3C, 5);
    tx_check(8'hC3, 5);

    // P = 8: framing error and 00h
    brk(5);
    calibrate(8);
    begin
      int v0, f0;
      v0 = n_valid;
      f0 = n_ferr;
      send_char(8'hA5, 8, 1'b1);
      chk(n_ferr == f0 + 1, "R6 framing error pulse", n_ferr - f0, 1);
      chk(n_valid == v0, "R6 no valid on framing error", n_valid - v0, 0);
    end
    rx_check(8'h3C, 8, "R6 receive after framing error");
    rx_check(8'h00, 8, "R7 00h received");
    chk(tx_ready == 1'b1, "R7 00h is not a break", int'(tx_ready), 1);
    tx_check(8'h5A, 8);

    // P = 13 (odd period)
    brk(8);
    calibrate(13);
    rx_check(8'h96, 13, "R9 rx P=13");
    rx_check(8'h7E, 13, "R5 rx P=13");
    tx_check(8'h69, 13);

    // slowest rate P = 512
    brk(13);
    calibrate(512);
    rx_check(8'hC3, 512, "R9 rx P=512");
    tx_check(8'h96, 512);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule